// File: doc/BRIEF.md
# Multi-Lane Bonding Deskew

This block lines up several parallel receive lanes whose symbols were sent in the same cycle but arrive with different delays. Every lane delivers one symbol per clock with a control-symbol flag and a valid strobe, and all lanes share one clock. The transmitter places the same bonding marker on every lane at the same moment. The block looks for that marker on each lane and records how many cycles after the first arrival each lane showed it. It then gives each lane its own delay, so that the last lane to arrive needs none and the earlier lanes wait for it. After that, words sent together leave the block together.

Once the lanes are bonded, the block watches the markers at its own outputs. A marker that shows on some outputs but not on all of them means the lanes have slipped. The block then drops `bonded` and starts a new search. If the marker arrivals in one search are spread too far apart for the delay lines to absorb, the block raises a one-cycle error and starts searching again.

Top module: `deskew_bond`

## Requirements
- R1: After synchronous reset, `bonded`, `skew_err` and `out_valid` are 0, and every lane delay is zero.
- R2: A lane symbol counts as a bonding marker only when its valid bit is 1, its K flag is 1 and its data equals MARKER (default 8'h7C). A data symbol 8'h7C with K=0, a K symbol with any other value (for example 8'hBC), and a marker with valid=0 all have no effect on the search.
- R3: Let F be the clock edge that samples the first marker of a search and L the edge that samples the last lane's marker, with L-F at most WINDOW-1 (7). Then `bonded` reads 1 after edge L+2 and not before.
- R4: From the edge at which `bonded` rises, each lane's delay equals the latest arrival time minus its own arrival time. Every output then carries, in the same cycle, the symbols sent in one transmit cycle: with skews s_l and the largest skew smax, the output after edge t holds transmit word t-T0-smax on every lane, where T0 is the edge that carries transmit word 0 on a lane with zero skew.
- R5: If no complete set of markers is seen by the edge F+WINDOW-1, `skew_err` is 1 for exactly the one cycle after that edge. The search restarts with nothing recorded, and `bonded` stays 0.
- R6: While bonded, a marker that appears on all lane outputs in the same cycle keeps `bonded` at 1. A marker that appears on some lane outputs but not on all of them clears `bonded` at the next edge and restarts the search.
- R7: `out_valid` is 1 only when the delayed valid bit of every lane is 1 for that output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all lanes |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | LANES*SYM_W | Received symbol of each lane, lane 0 in the low bits |
| in_k | input | LANES | Control-symbol flag of each lane |
| in_valid | input | LANES | Symbol valid strobe of each lane |
| out_data | output | LANES*SYM_W | Deskewed symbol of each lane |
| out_k | output | LANES | Deskewed control-symbol flag of each lane |
| out_valid | output | 1 | All lanes hold valid symbols this cycle |
| bonded | output | 1 | Lanes are aligned and the markers still agree |
| skew_err | output | 1 | One-cycle pulse: marker spread exceeded the window |

## Verification
Timing is counted from the edge that samples the last lane's marker. The block changes its delays one edge after that, and `bonded` reads 1 one edge later. From then on, the outputs after edge t hold transmit word t-T0-smax, so each output lags the input of its latest lane by one register. A slipped marker clears `bonded` one edge after it appears at the outputs. A window overrun pulses `skew_err` just after edge F+7. For each edge, the driver pushes the expected item into the scoreboard before the edge. The monitor pops it two time units after the edge, so every expected value is tied to the exact edge at which the requirement says it is due.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_ALIGN  = 2'd1,
    ST_BONDED = 2'd2
  } bond_state_e;

endpackage

// File: rtl/deskew_marker_det.sv
module deskew_marker_det #(
  parameter int               SYM_W  = 8,
  parameter logic [SYM_W-1:0] MARKER = 8'h7C
) (
  input  logic             sym_valid,
  input  logic             sym_k,
  input  logic [SYM_W-1:0] sym_data,
  output logic             hit
);

  // a marker needs all three qualifiers at once
  assign hit = sym_valid && sym_k && (sym_data == MARKER);

endmodule

// File: rtl/deskew_lane_delay.sv
module deskew_lane_delay #(
  parameter int SYM_W = 8,
  parameter int DEPTH = 8,
  parameter int DLY_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_k,
  input  logic [SYM_W-1:0] in_data,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             out_valid,
  output logic             out_k,
  output logic [SYM_W-1:0] out_data
);

  localparam int ENT_W = SYM_W + 2;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [DLY_W-1:0] wptr;
  logic [DLY_W-1:0] rptr;
  logic [DLY_W-1:0] dly;
  logic [ENT_W-1:0] wr_ent;
  logic [ENT_W-1:0] rd_ent;
  logic [ENT_W-1:0] sel_ent;

  assign wr_ent = {in_valid, in_k, in_data};
  assign rptr   = wptr - dly;
  assign rd_ent = mem[rptr];
  assign sel_ent = (dly == '0) ? wr_ent : rd_ent;

  // history store, written every cycle, no reset so it maps to RAM
  always_ff @(posedge clk) begin
    mem[wptr] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      dly  <= '0;
      {out_valid, out_k, out_data} <= '0;
    end else begin
      wptr <= wptr + 1'b1;
      if (load) dly <= load_val;
      {out_valid, out_k, out_data} <= sel_ent;
    end
  end

  // R4: with no delay the lane is a single register stage
  a_r4_zero_delay_passthru: assert property (@(posedge clk) disable iff (rst)
    (dly == '0 && !load) |=> (out_data == $past(in_data) && out_k == $past(in_k)
                              && out_valid == $past(in_valid)));

endmodule

// File: rtl/deskew_bond_fsm.sv
module deskew_bond_fsm
  import deskew_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int WINDOW = 8,
  parameter int DLY_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       in_hit,
  input  logic [LANES-1:0]       out_hit,
  output logic                   dly_load,
  output logic [LANES*DLY_W-1:0] dly_val,
  output logic                   bonded,
  output logic                   skew_err
);

  localparam int ARR_W = $clog2(WINDOW);

  bond_state_e      state;
  logic             settle;
  logic [LANES-1:0] seen;
  logic [ARR_W-1:0] wcnt;
  logic [ARR_W-1:0] arr [LANES];

  logic [LANES-1:0] new_hit;
  logic [LANES-1:0] seen_nx;
  logic             all_seen;
  logic             active;
  logic [ARR_W-1:0] cur_t;
  logic [ARR_W-1:0] max_arr;
  logic             out_partial;

  always_comb begin
    new_hit  = in_hit & ~seen;
    seen_nx  = seen | in_hit;
    all_seen = &seen_nx;
    active   = (seen != '0) || (in_hit != '0);
    cur_t    = (seen == '0) ? '0 : wcnt;
    max_arr  = '0;
    for (int l = 0; l < LANES; l++) begin
      if (arr[l] > max_arr) max_arr = arr[l];
    end
  end

  // latest lane gets zero, earlier lanes wait for it
  for (genvar l = 0; l < LANES; l++) begin : g_dly
    assign dly_val[l*DLY_W +: DLY_W] = DLY_W'(max_arr - arr[l]);
  end

  assign dly_load    = (state == ST_ALIGN) && !settle;
  assign out_partial = (out_hit != '0) && (out_hit != '1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SEARCH;
      settle   <= 1'b0;
      seen     <= '0;
      wcnt     <= '0;
      bonded   <= 1'b0;
      skew_err <= 1'b0;
      for (int l = 0; l < LANES; l++) arr[l] <= '0;
    end else begin
      skew_err <= 1'b0;
      case (state)
        ST_SEARCH: begin
          for (int l = 0; l < LANES; l++) begin
            if (new_hit[l]) arr[l] <= cur_t;
          end
          if (active) begin
            if (all_seen) begin
              state <= ST_ALIGN;
              seen  <= '0;
              wcnt  <= '0;
            end else if ((seen != '0) && (wcnt == ARR_W'(WINDOW - 1))) begin
              skew_err <= 1'b1;
              seen     <= '0;
              wcnt     <= '0;
            end else begin
              seen <= seen_nx;
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        ST_ALIGN: begin
          // first cycle loads delays, second lets the outputs settle
          if (!settle) begin
            settle <= 1'b1;
          end else begin
            settle <= 1'b0;
            state  <= ST_BONDED;
            bonded <= 1'b1;
          end
        end
        ST_BONDED: begin
          if (out_partial) begin
            state  <= ST_SEARCH;
            bonded <= 1'b0;
          end
        end
        default: begin
          state  <= ST_SEARCH;
          bonded <= 1'b0;
        end
      endcase
    end
  end

  // R5: an overrun never coincides with a bonded link
  a_r5_err_not_bonded: assert property (@(posedge clk) disable iff (rst)
    skew_err |-> !bonded);

  // R6: a partial marker at the outputs breaks the bond
  a_r6_partial_drops: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BONDED && out_partial) |=> (!bonded && state == ST_SEARCH));

  // R3: the bond is only ever granted out of the align step
  a_r3_rise_from_align: assert property (@(posedge clk) disable iff (rst)
    $rose(bonded) |-> $past(state == ST_ALIGN));

  // R2: with nothing recorded and no marker, the search stays idle
  a_r2_idle_search: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH && seen == '0 && in_hit == '0) |=> (seen == '0 && !skew_err));

endmodule

// File: rtl/deskew_bond.sv
module deskew_bond #(
  parameter int               LANES  = 4,
  parameter int               SYM_W  = 8,
  parameter int               DEPTH  = 8,
  parameter int               WINDOW = 8,
  parameter logic [SYM_W-1:0] MARKER = 8'h7C
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*SYM_W-1:0] in_data,
  input  logic [LANES-1:0]       in_k,
  input  logic [LANES-1:0]       in_valid,
  output logic [LANES*SYM_W-1:0] out_data,
  output logic [LANES-1:0]       out_k,
  output logic                   out_valid,
  output logic                   bonded,
  output logic                   skew_err
);

  localparam int DLY_W = $clog2(DEPTH);

  logic [LANES-1:0]       in_hit;
  logic [LANES-1:0]       out_hit;
  logic [LANES-1:0]       lane_v;
  logic                   dly_load;
  logic [LANES*DLY_W-1:0] dly_val;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    deskew_marker_det #(.SYM_W(SYM_W), .MARKER(MARKER)) i_det_in (
      .sym_valid (in_valid[l]),
      .sym_k     (in_k[l]),
      .sym_data  (in_data[l*SYM_W +: SYM_W]),
      .hit       (in_hit[l])
    );

    deskew_lane_delay #(.SYM_W(SYM_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) i_dly (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid[l]),
      .in_k      (in_k[l]),
      .in_data   (in_data[l*SYM_W +: SYM_W]),
      .load      (dly_load),
      .load_val  (dly_val[l*DLY_W +: DLY_W]),
      .out_valid (lane_v[l]),
      .out_k     (out_k[l]),
      .out_data  (out_data[l*SYM_W +: SYM_W])
    );

    deskew_marker_det #(.SYM_W(SYM_W), .MARKER(MARKER)) i_det_out (
      .sym_valid (lane_v[l]),
      .sym_k     (out_k[l]),
      .sym_data  (out_data[l*SYM_W +: SYM_W]),
      .hit       (out_hit[l])
    );
  end

  assign out_valid = &lane_v;

  deskew_bond_fsm #(.LANES(LANES), .WINDOW(WINDOW), .DLY_W(DLY_W)) i_fsm (
    .clk      (clk),
    .rst      (rst),
    .in_hit   (in_hit),
    .out_hit  (out_hit),
    .dly_load (dly_load),
    .dly_val  (dly_val),
    .bonded   (bonded),
    .skew_err (skew_err)
  );

  // R1: the first cycle out of reset shows an idle, unbonded block
  a_r1_reset_idle: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (!bonded && !skew_err && !out_valid));

endmodule

// File: tb/test_deskew_bond.sv
module test_deskew_bond;

  localparam int LANES = 4;
  localparam int SYM_W = 8;
  localparam logic [7:0] MRK = 8'h7C;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [LANES*SYM_W-1:0] in_data = '0;
  logic [LANES-1:0]       in_k = '0;
  logic [LANES-1:0]       in_valid = '0;
  logic [LANES*SYM_W-1:0] out_data;
  logic [LANES-1:0]       out_k;
  logic                   out_valid;
  logic                   bonded;
  logic                   skew_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    int                     t;
    bit                     chk_d;
    bit                     exp_b;
    bit                     exp_e;
    bit                     exp_v;
    logic [LANES*SYM_W-1:0] exp_d;
    logic [LANES-1:0]       exp_k;
  } item_t;

  item_t sb[$];

  always #5 clk = ~clk;

  deskew_bond i_deskew_bond (
    .clk(clk), .rst(rst), .in_data(in_data), .in_k(in_k), .in_valid(in_valid),
    .out_data(out_data), .out_k(out_k), .out_valid(out_valid),
    .bonded(bonded), .skew_err(skew_err)
  );

  // transmitted symbol {valid, k, data} for word n of lane l in phase ph
  function automatic logic [9:0] tx_word(int ph, int n, int l);
    logic [7:0] nd;
    nd = 8'((n * 37 + l * 11 + 3) % 256);
    if (n < 0) return 10'd0;
    if (ph == 2) return (n == 5) ? {2'b11, MRK} : {2'b10, nd};
    if (n == 10 || n == 40 || n == 60 || n == 80) return {2'b11, MRK};
    if (n == 70) return {2'b01, MRK};             // R2: invalid marker
    if (n == 5)  return {2'b10, MRK};             // R2: data byte, no K
    if (n == 6)  return {2'b11, 8'hBC};           // R2: other K symbol
    if ((n == 30 && l == 2) || n == 90) return {2'b00, nd};
    return {2'b10, nd};
  endfunction

  function automatic int skew_of(int ph, int l, int t);
    if (ph == 2) return (l == 1) ? 8 : 0;
    case (l)
      0: return (t >= 45) ? 1 : 0;                // slip on lane 0
      1: return 7;
      2: return 2;
      default: return 4;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int t, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s t=%0d got %0h expected %0h", req, what, t, got, exp);
    end
  endtask

  // driver: sets lane inputs for edge T0+t and queues what is due after it
  task automatic run_phase(int ph, int n_edges);
    for (int t = 0; t < n_edges; t++) begin
      item_t it;
      @(negedge clk);
      for (int l = 0; l < LANES; l++) begin
        logic [9:0] w;
        w = tx_word(ph, t - skew_of(ph, l, t), l);
        in_valid[l] = w[9];
        in_k[l]     = w[8];
        in_data[l*SYM_W +: SYM_W] = w[7:0];
      end
      it.t = t;
      if (ph == 1) begin
        it.exp_b = (t >= 19 && t <= 67) || (t >= 89);
        it.exp_e = 1'b0;
        it.chk_d = (t >= 19 && t < 45) || (t >= 89);
      end else begin
        it.exp_b = 1'b0;
        it.exp_e = (t == 12) || (t == 20);
        it.chk_d = 1'b0;
      end
      it.exp_v = 1'b1;
      for (int l = 0; l < LANES; l++) begin
        logic [9:0] w;
        w = tx_word(ph, t - 7, l);
        it.exp_v = it.exp_v & w[9];
        it.exp_k[l] = w[8];
        it.exp_d[l*SYM_W +: SYM_W] = w[7:0];
      end
      sb.push_back(it);
    end
    @(negedge clk);
    in_valid = '0; in_k = '0; in_data = '0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // monitor: compares outputs away from the edge
  always @(posedge clk) begin
    #2;
    if (sb.size() != 0) begin
      item_t it;
      it = sb.pop_front();
      chk(bonded == it.exp_b, "R2/R3/R6", "bonded", it.t, 64'(bonded), 64'(it.exp_b));
      chk(skew_err == it.exp_e, "R5", "skew_err", it.t, 64'(skew_err), 64'(it.exp_e));
      if (it.chk_d) begin
        chk(out_valid == it.exp_v, "R7", "out_valid", it.t, 64'(out_valid), 64'(it.exp_v));
        if (it.exp_v)
          chk(out_data == it.exp_d && out_k == it.exp_k, "R4", "lanes",
              it.t, {28'd0, out_k, out_data}, {28'd0, it.exp_k, it.exp_d});
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    in_valid = '0; in_k = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #2;
    chk(!bonded, "R1", "bonded", 0, 64'(bonded), 64'd0);
    chk(!skew_err, "R1", "skew_err", 0, 64'(skew_err), 64'd0);
    chk(!out_valid, "R1", "out_valid", 0, 64'(out_valid), 64'd0);
  endtask

  initial begin
    do_reset();
    run_phase(1, 111);   // R3/R4/R6/R7 with skews 0,7,2,4 and a lane slip
    do_reset();
    run_phase(2, 31);    // R5: lane 1 eight cycles late
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got running expected finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule